// File: doc/BRIEF.md
# Dual-Half Interrupt Controller

This block gathers interrupt requests from up to 32 peripheral sources on behalf of a single CPU. Each source pulses its own line to latch a pending flag. Software sees three registers: a one-bit master enable, a 32-bit enable mask and a 32-bit pending set. The mask and the pending set are each reached as two 16-bit halves. Pending flags are cleared by writing ones to them.

The controller drives two signals to the core. The first is a one-cycle wake pulse, which brings the core out of halt whenever an enabled source fires, whatever the master enable holds. The second is an interrupt request. It is armed only by certain events: an enabled source firing, a write to the mask, or a write to the master enable. It is armed only if, after that event, the master enable is on and some flag is both pending and enabled. An armed request waits while the core's interrupt-disable input is high. It is delivered as a single-cycle pulse once that input is low, and it is disarmed as soon as its condition no longer holds.

Top module: `irq_pair_ctrl`

## Requirements
- R1: After reset, active or reapplied mid-run, every register reads zero and both irqReq and wakeOut are low.
- R2: Register addresses are: 0 = master enable, 1 = mask sources 0..15, 2 = mask sources 16..31, 3 = pending sources 0..15, 4 = pending sources 16..31. Mask writes read back unchanged, and any other address reads zero.
- R3: A pulse on srcRaise[n] sets pending bit n%16 of the half selected by n/16, visible from the next cycle.
- R4: A write to a pending half clears exactly the bits written as 1; bits written as 0 keep their value.
- R5: When a pending bit is cleared and raised in the same cycle, it ends up set.
- R6: The master enable holds only data bit 0; reads of address 0 return zero in bits 15..1.
- R7: When a raised source is enabled in the mask, wakeOut is high for the cycle after the edge, regardless of the master enable. A raised source that is not enabled gives no wake.
- R8: irqReq is high only while the master enable is on and some bit is both enabled and pending.
- R9: A mask write, a master-enable write, or the raising of an enabled source arms a request when the condition holds after the write; irqReq then rises in the cycle after the edge. Pending writes and the raising of a disabled source do not arm it.
- R10: While cpuIrqDisable is high an armed request is held with irqReq low. Once the input is low, irqReq stays high for exactly one cycle, and the request is then consumed.
- R11: An armed request is discarded when its condition stops holding before delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for writes and reads |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for regAddr (combinational) |
| srcRaise | input | 32 | One pulse per source event |
| cpuIrqDisable | input | 1 | Core's interrupt-disable flag |
| irqReq | output | 1 | Interrupt request pulse to the core |
| wakeOut | output | 1 | Leave-halt pulse to the core |

## Verification
The properties assume that srcRaise bits are single-cycle pulses, and that after a delivered request the core writes nothing and raises nothing before the next edge unless it intends a new arming event. In the stimulus, every raise and write lasts exactly one cycle. All inputs change one time unit after the rising edge or at the falling edge, never at the sampling edge. cpuIrqDisable is changed only just after an edge, so each hold-and-release case falls at a known cycle.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
  localparam int IRQP_HALF_W   = 16;
  localparam int IRQP_NUM_HALF = 2;
  localparam int IRQP_ADDR_W   = 3;

  // Address layout: master enable, then mask halves, then pending halves
  localparam int IRQP_IME_ADDR = 0;
  localparam int IRQP_IE_BASE  = 1;
  localparam int IRQP_IF_BASE  = IRQP_IE_BASE + IRQP_NUM_HALF;

  typedef struct packed {
    logic                     imeWr;
    logic [IRQP_NUM_HALF-1:0] ieWr;
    logic [IRQP_NUM_HALF-1:0] ifClr;
  } irqStrobe_t;
endpackage

// File: rtl/irq_pair_datapath.sv
module irq_pair_datapath
  import irq_pair_pkg::*;
#(
  parameter int HALF_W   = IRQP_HALF_W,
  parameter int NUM_HALF = IRQP_NUM_HALF,
  parameter int ADDR_W   = IRQP_ADDR_W,
  localparam int NUM_SRC = HALF_W * NUM_HALF
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strb,
  input  logic [HALF_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] srcRaise,
  output logic [HALF_W-1:0]  rdData,
  output logic               condNext,
  output logic               raiseEnNext,
  output logic               enRaise,
  output logic [NUM_SRC-1:0] ieAll,
  output logic [NUM_SRC-1:0] ifAll,
  output logic               imeOn
);
  logic [HALF_W-1:0]  ieQ [NUM_HALF];
  logic [HALF_W-1:0]  ifQ [NUM_HALF];
  logic [NUM_SRC-1:0] ieNextAll;
  logic [NUM_SRC-1:0] ifNextAll;
  logic               imeQ;
  logic               imeNext;

  assign imeNext = strb.imeWr ? wrData[0] : imeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) imeQ <= 1'b0;
    else       imeQ <= imeNext;
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic [HALF_W-1:0] ieNext;
    logic [HALF_W-1:0] clrMask;
    logic [HALF_W-1:0] ifNext;

    assign ieNext  = strb.ieWr[h] ? wrData : ieQ[h];
    assign clrMask = strb.ifClr[h] ? wrData : '0;
    // a raise in the same cycle overrides a clear
    assign ifNext  = (ifQ[h] & ~clrMask) | srcRaise[h*HALF_W +: HALF_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ieQ[h] <= '0;
        ifQ[h] <= '0;
      end else begin
        ieQ[h] <= ieNext;
        ifQ[h] <= ifNext;
      end
    end

    assign ieAll[h*HALF_W +: HALF_W]     = ieQ[h];
    assign ifAll[h*HALF_W +: HALF_W]     = ifQ[h];
    assign ieNextAll[h*HALF_W +: HALF_W] = ieNext;
    assign ifNextAll[h*HALF_W +: HALF_W] = ifNext;
  end

  assign imeOn       = imeQ;
  assign condNext    = imeNext & (|(ieNextAll & ifNextAll));
  assign raiseEnNext = |(srcRaise & ieNextAll);
  assign enRaise     = |(srcRaise & ieAll);

  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_W'(IRQP_IME_ADDR)) rdData = {{(HALF_W-1){1'b0}}, imeQ};
    for (int h = 0; h < NUM_HALF; h++) begin
      if (regAddr == ADDR_W'(IRQP_IE_BASE + h)) rdData = ieQ[h];
      if (regAddr == ADDR_W'(IRQP_IF_BASE + h)) rdData = ifQ[h];
    end
  end
endmodule

// File: rtl/irq_pair_control.sv
module irq_pair_control
  import irq_pair_pkg::*;
#(
  parameter int NUM_HALF = IRQP_NUM_HALF,
  parameter int ADDR_W   = IRQP_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              cpuIrqDisable,
  input  logic              condNext,
  input  logic              raiseEnNext,
  input  logic              enRaise,
  output irqStrobe_t        strb,
  output logic              irqReq,
  output logic              wakeOut
);
  logic armQ;
  logic armNext;
  logic trigger;
  logic wakeQ;

  always_comb begin
    strb       = '0;
    strb.imeWr = wrEn && (regAddr == ADDR_W'(IRQP_IME_ADDR));
    for (int h = 0; h < NUM_HALF; h++) begin
      strb.ieWr[h]  = wrEn && (regAddr == ADDR_W'(IRQP_IE_BASE + h));
      strb.ifClr[h] = wrEn && (regAddr == ADDR_W'(IRQP_IF_BASE + h));
    end
  end

  // arming events: enabled raise, mask write, master-enable write
  assign trigger = raiseEnNext | strb.imeWr | (|strb.ieWr);
  assign irqReq  = armQ & ~cpuIrqDisable;
  // consume on delivery, re-arm on an event, drop when condition fails
  assign armNext = ((armQ & ~irqReq) | trigger) & condNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ  <= 1'b0;
      wakeQ <= 1'b0;
    end else begin
      armQ  <= armNext;
      wakeQ <= enRaise;
    end
  end

  assign wakeOut = wakeQ;
endmodule

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl
  import irq_pair_pkg::*;
#(
  parameter int HALF_W   = IRQP_HALF_W,
  parameter int NUM_HALF = IRQP_NUM_HALF,
  parameter int ADDR_W   = IRQP_ADDR_W,
  localparam int NUM_SRC = HALF_W * NUM_HALF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [HALF_W-1:0]  wrData,
  output logic [HALF_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcRaise,
  input  logic               cpuIrqDisable,
  output logic               irqReq,
  output logic               wakeOut
);
  irqStrobe_t         strb;
  logic               condNext;
  logic               raiseEnNext;
  logic               enRaise;
  logic [NUM_SRC-1:0] ieAll;
  logic [NUM_SRC-1:0] ifAll;
  logic               imeOn;

  irq_pair_control #(.NUM_HALF(NUM_HALF), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .cpuIrqDisable(cpuIrqDisable), .condNext(condNext),
    .raiseEnNext(raiseEnNext), .enRaise(enRaise), .strb(strb),
    .irqReq(irqReq), .wakeOut(wakeOut)
  );

  irq_pair_datapath #(.HALF_W(HALF_W), .NUM_HALF(NUM_HALF), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .regAddr(regAddr),
    .srcRaise(srcRaise), .rdData(rdData), .condNext(condNext),
    .raiseEnNext(raiseEnNext), .enRaise(enRaise), .ieAll(ieAll),
    .ifAll(ifAll), .imeOn(imeOn)
  );
endmodule

// File: rtl/irq_pair_ctrl_chk.sv
module irq_pair_ctrl_chk #(
  parameter int HALF_W   = 16,
  parameter int NUM_HALF = 2,
  parameter int ADDR_W   = 3,
  localparam int NUM_SRC = HALF_W * NUM_HALF
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [HALF_W-1:0]  rdData,
  input logic [NUM_SRC-1:0] srcRaise,
  input logic               cpuIrqDisable,
  input logic               irqReq,
  input logic               wakeOut,
  input logic [NUM_SRC-1:0] ieAll,
  input logic [NUM_SRC-1:0] ifAll,
  input logic               imeOn
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !cpuIrqDisable); // R10
  AST_IRQ_COND: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (imeOn && (|(ieAll & ifAll)))); // R8
  AST_WAKE_ANY_IME: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcRaise & ieAll)) |=> wakeOut); // R7
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|srcRaise) |=> ((ifAll & $past(srcRaise)) == $past(srcRaise))); // R5
  AST_DELIVER_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !wrEn && (srcRaise == '0)) |=> !irqReq); // R10
  AST_IME_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> (rdData[HALF_W-1:1] == '0)); // R6
endmodule

bind irq_pair_ctrl irq_pair_ctrl_chk #(.HALF_W(HALF_W), .NUM_HALF(NUM_HALF), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .rdData(rdData),
  .srcRaise(srcRaise), .cpuIrqDisable(cpuIrqDisable), .irqReq(irqReq),
  .wakeOut(wakeOut), .ieAll(ieAll), .ifAll(ifAll), .imeOn(imeOn)
);

// File: tb/sim_irq_pair_ctrl.sv
module sim_irq_pair_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic        w;
    logic [2:0]  a;
    logic [15:0] d;
    logic [31:0] r;
    logic        dis;
    logic        eIrq;
    logic        eWake;
    logic [2:0]  rdA;
    logic [15:0] eRd;
    logic [7:0]  tag;
  } vec_t;

  // dis: value of cpuIrqDisable applied just after this vector's edge
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd1, 16'h0005, 32'h0,        1'b0, 1'b0, 1'b0, 3'd1, 16'h0005, 8'd2},  // R2
    '{1'b1, 3'd2, 16'h8001, 32'h0,        1'b0, 1'b0, 1'b0, 3'd2, 16'h8001, 8'd2},  // R2
    '{1'b0, 3'd0, 16'h0000, 32'h4,        1'b0, 1'b0, 1'b1, 3'd3, 16'h0004, 8'd7},  // R7
    '{1'b0, 3'd0, 16'h0000, 32'h80000000, 1'b0, 1'b0, 1'b1, 3'd4, 16'h8000, 8'd3},  // R3
    '{1'b0, 3'd0, 16'h0000, 32'h2,        1'b0, 1'b0, 1'b0, 3'd3, 16'h0006, 8'd7},  // R7
    '{1'b1, 3'd0, 16'hFFFF, 32'h0,        1'b0, 1'b1, 1'b0, 3'd0, 16'h0001, 8'd9},  // R9
    '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 1'b0, 1'b0, 3'd0, 16'h0001, 8'd10}, // R10
    '{1'b1, 3'd3, 16'h0004, 32'h0,        1'b0, 1'b0, 1'b0, 3'd3, 16'h0002, 8'd4},  // R4
    '{1'b1, 3'd3, 16'h0000, 32'h0,        1'b1, 1'b0, 1'b0, 3'd3, 16'h0002, 8'd4},  // R4
    '{1'b0, 3'd0, 16'h0000, 32'h1,        1'b1, 1'b0, 1'b1, 3'd3, 16'h0003, 8'd10}, // R10
    '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 1'b1, 1'b0, 3'd3, 16'h0003, 8'd10}, // R10
    '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 1'b0, 1'b0, 3'd3, 16'h0003, 8'd10}, // R10
    '{1'b1, 3'd1, 16'h0007, 32'h0,        1'b1, 1'b0, 1'b0, 3'd1, 16'h0007, 8'd9},  // R9
    '{1'b1, 3'd0, 16'h0000, 32'h0,        1'b0, 1'b0, 1'b0, 3'd0, 16'h0000, 8'd11}, // R11
    '{1'b1, 3'd0, 16'h0001, 32'h0,        1'b0, 1'b1, 1'b0, 3'd0, 16'h0001, 8'd9},  // R9
    '{1'b1, 3'd3, 16'h0001, 32'h1,        1'b0, 1'b1, 1'b1, 3'd3, 16'h0003, 8'd5},  // R5
    '{1'b1, 3'd3, 16'h0003, 32'h0,        1'b0, 1'b0, 1'b0, 3'd3, 16'h0000, 8'd4},  // R4
    '{1'b1, 3'd4, 16'h8000, 32'h0,        1'b0, 1'b0, 1'b0, 3'd4, 16'h0000, 8'd4}   // R4
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [31:0] srcRaise = '0;
  logic        cpuIrqDisable = 1'b0;
  logic        irqReq;
  logic        wakeOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pair_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .srcRaise(srcRaise), .cpuIrqDisable(cpuIrqDisable),
    .irqReq(irqReq), .wakeOut(wakeOut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doCycle(input logic w, input logic [2:0] a, input logic [15:0] d,
                         input logic [31:0] r, input logic disAfter);
    @(negedge clk);
    wrEn = w; regAddr = a; wrData = d; srcRaise = r;
    @(posedge clk);
    #1;
    wrEn = 1'b0; srcRaise = '0; cpuIrqDisable = disAfter;
    #1;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic checkAllZero(input string req);
    logic [15:0] v;
    chk(req, "irqReq", {31'b0, irqReq}, 32'h0);
    chk(req, "wakeOut", {31'b0, wakeOut}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), v);
      chk(req, $sformatf("reg%0d", a), {16'h0, v}, 32'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    checkAllZero("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAllZero("R1");

    // R3: every source lands in its own half and bit; disabled so no wake (R7) and no request (R9)
    for (int n = 0; n < 32; n++) begin
      doCycle(1'b0, 3'd0, 16'h0, 32'h1 << n, 1'b0);
      readReg(3'(3 + n / 16), v);
      chk("R3", $sformatf("src%0d pending", n), {16'h0, v}, 32'h1 << (n % 16));
      chk("R7", $sformatf("src%0d no wake", n), {31'b0, wakeOut}, 32'h0);
      chk("R9", $sformatf("src%0d no irq", n), {31'b0, irqReq}, 32'h0);
      doCycle(1'b1, 3'(3 + n / 16), 16'h1 << (n % 16), 32'h0, 1'b0);
      readReg(3'(3 + n / 16), v);
      chk("R4", $sformatf("src%0d cleared", n), {16'h0, v}, 32'h0);
    end

    for (int i = 0; i < NVEC; i++) begin
      doCycle(VECS[i].w, VECS[i].a, VECS[i].d, VECS[i].r, VECS[i].dis);
      chk($sformatf("R%0d", VECS[i].tag), $sformatf("vec%0d irqReq", i), {31'b0, irqReq}, {31'b0, VECS[i].eIrq});
      chk($sformatf("R%0d", VECS[i].tag), $sformatf("vec%0d wakeOut", i), {31'b0, wakeOut}, {31'b0, VECS[i].eWake});
      readReg(VECS[i].rdA, v);
      chk($sformatf("R%0d", VECS[i].tag), $sformatf("vec%0d read", i), {16'h0, v}, {16'h0, VECS[i].eRd});
    end

    // R1: reset reapplied with state present
    doCycle(1'b0, 3'd0, 16'h0, 32'h00010001, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkAllZero("R1");
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule